// File: doc/BRIEF.md
# Transmit Path Fault Monitor

This block watches the digital side of a bus transceiver's transmit path and decides when the transmitter must be switched off. Its inputs are the transmit data line, the receive data line, a bus-dominant indication from the receiver, and an overtemperature input. The operating mode comes from the mode controller.

It detects four local faults:

- a transmit input held dominant for too long;
- a short between the transmit and receive pins;
- a bus clamped dominant;
- overtemperature.

From these it drives a local-failure flag and a transmitter-disable output. The bus-clamp fault only raises the flag, and only while it lasts. The other three latch and also disable the transmitter.

In normal mode the block also measures each dominant-to-recessive transmit cycle. In each cycle it checks whether the bus followed the transmit line into the dominant state within a loop delay. Four failing cycles in a row set a bus-failure flag.

Signal levels: transmit and receive are low for dominant. The bus-dominant input and all flag outputs are high-active. All timing is counted in clock cycles, and "sampled on N edges" means N consecutive rising clock edges.

Top module: `txpath_fault_mon`

## Requirements
- R1: While `rst_n` is low and on the first edge after its release (mode standby, all lines idle), `local_fail`, `tx_disable` and `bus_fail` are 0.
- R2: In an active mode, a `tx_in` of 0 sampled on TXD_TO_CYC+1 edges sets `local_fail` and `tx_disable` after the last of them. TXD_TO_CYC edges alone set nothing.
- R3: In an active mode, an `overtemp` of 1 sampled on one edge sets `local_fail` and `tx_disable` after that edge.
- R4: In an active mode, `rx_in`=0, `tx_in`=1 and `bus_dom`=0 sampled together on SHORT_CYC+1 edges set `local_fail` and `tx_disable`. SHORT_CYC edges alone set nothing.
- R5: In an active mode, `bus_dom`=1 sampled on BUS_TO_CYC+1 edges sets `local_fail` with `tx_disable` left at 0. The first edge that samples `bus_dom`=0 returns `local_fail` to 0 when no latched fault exists.
- R6: Faults from R2, R3 and R4 stay latched, with `tx_disable` at 1, until a clear from R7 or R8.
- R7: An edge that samples `mode`=01 (normal) after the previous edge sampled another mode clears all latched local faults.
- R8: In an active mode, an edge that samples `rx_in`=0, `tx_in`=1 and `overtemp`=0, while neither the short timer of R4 nor the clamp timer of R5 has expired, clears all latched local faults. With `overtemp`=1 this clear does not happen.
- R9: Mode encoding: 00 standby, 01 normal, 10 listen-only, 11 sleep. Local fault detection works only in 01 and 10; in 00 and 11 no local fault is set.
- R10: In mode 01 with `tx_disable` at 0, a transmit cycle fails if `bus_dom` is not sampled 1 within the first LOOP_DLY edges of the dominant phase. The failure is judged on the edge that first samples `tx_in`=1 again. FAIL_CYCLES consecutive failing cycles set `bus_fail` on that edge. A good cycle restarts the count.
- R11: Entering normal mode as in R7 clears `bus_fail`.
- R12: When a fault is detected on the same edge as a clear, the fault wins and the flag is 1 after that edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low (power-on) |
| mode | input | 2 | Operating mode from the mode controller |
| tx_in | input | 1 | Transmit data input, 0 = dominant |
| rx_in | input | 1 | Receive data line level, 0 = dominant |
| bus_dom | input | 1 | Bus differential reads dominant |
| overtemp | input | 1 | Overtemperature indication |
| local_fail | output | 1 | Local-failure flag |
| tx_disable | output | 1 | Transmitter disable |
| bus_fail | output | 1 | Bus-failure flag |

## Verification
The two actions that can fall on one edge are the setting of a latched local fault and the entry-into-normal clear.

The bench provokes this by moving the mode from listen-only to normal on the same edge that first samples overtemperature. The block is correct only if both `local_fail` and `tx_disable` read 1 after that edge.

A related case checks that the receive-dominant clear is suppressed when the short timer expires on that same edge. The bench also checks that a bus that turns dominant one edge after the loop-delay window still counts as a failed cycle.

// File: rtl/txfm_pkg.sv
package txfm_pkg;

  typedef enum logic [1:0] {
    MD_STANDBY = 2'b00,
    MD_NORMAL  = 2'b01,
    MD_LISTEN  = 2'b10,
    MD_SLEEP   = 2'b11
  } mode_e;

  // local fault detection window: normal and listen-only
  function automatic logic det_active(input logic [1:0] m);
    return (m == MD_NORMAL) || (m == MD_LISTEN);
  endfunction

  function automatic logic entering_normal(input logic [1:0] cur, input logic [1:0] prev);
    return (cur == MD_NORMAL) && (prev != MD_NORMAL);
  endfunction

  function automatic logic release_ok(input logic rx, input logic tx, input logic ot,
                                      input logic short_hit, input logic clamp_hit);
    return !rx && tx && !ot && !short_hit && !clamp_hit;
  endfunction

endpackage

// File: rtl/txfm_persist_timer.sv
module txfm_persist_timer #(
  parameter int LIMIT = 8
) (
  input  logic clk,
  input  logic rst_n,
  input  logic en,
  input  logic cond,
  output logic expire
);
  localparam int W = $clog2(LIMIT + 1);

  logic [W-1:0] cnt;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)              cnt <= '0;
    else if (!(en && cond))  cnt <= '0;
    else if (cnt != W'(LIMIT)) cnt <= cnt + 1'b1;
  end

  // condition already held on LIMIT earlier edges and still holds
  assign expire = en && cond && (cnt == W'(LIMIT));
endmodule

// File: rtl/txfm_local_faults.sv
module txfm_local_faults #(
  parameter int TXD_TO_CYC = 100000,
  parameter int SHORT_CYC  = 16,
  parameter int BUS_TO_CYC = 100000
) (
  input  logic clk,
  input  logic rst_n,
  input  logic act,
  input  logic tx_in,
  input  logic rx_in,
  input  logic bus_dom,
  input  logic overtemp,
  input  logic clr,
  output logic short_hit,
  output logic clamp_hit,
  output logic latched_any,
  output logic clamp_flag
);
  localparam int NSRC = 3;

  function automatic int lim_sel(input int i);
    case (i)
      0:       return TXD_TO_CYC;
      1:       return SHORT_CYC;
      default: return BUS_TO_CYC;
    endcase
  endfunction

  logic [NSRC-1:0] cond;
  logic [NSRC-1:0] hit;
  logic [2:0]      set_v;
  logic [2:0]      lat;

  assign cond[0] = !tx_in;
  assign cond[1] = !rx_in && tx_in && !bus_dom;
  assign cond[2] = bus_dom;

  for (genvar g = 0; g < NSRC; g++) begin : g_tmr
    txfm_persist_timer #(.LIMIT(lim_sel(g))) u_tmr (
      .clk   (clk),
      .rst_n (rst_n),
      .en    (act),
      .cond  (cond[g]),
      .expire(hit[g])
    );
  end

  assign set_v = {act && overtemp, hit[1], hit[0]};

  // set has priority over every clear
  for (genvar k = 0; k < 3; k++) begin : g_lat
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)        lat[k] <= 1'b0;
      else if (set_v[k]) lat[k] <= 1'b1;
      else if (clr)      lat[k] <= 1'b0;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) clamp_flag <= 1'b0;
    else        clamp_flag <= hit[2];
  end

  assign short_hit   = hit[1];
  assign clamp_hit   = hit[2];
  assign latched_any = |lat;
endmodule

// File: rtl/txfm_bus_fault.sv
module txfm_bus_fault #(
  parameter int LOOP_DLY    = 8,
  parameter int FAIL_CYCLES = 4
) (
  input  logic clk,
  input  logic rst_n,
  input  logic drv_ok,
  input  logic tx_in,
  input  logic bus_dom,
  input  logic enter_norm,
  output logic bus_fail
);
  localparam int PW = $clog2(LOOP_DLY + 1);
  localparam int FW = $clog2(FAIL_CYCLES + 1);

  logic          tx_q;
  logic          seen;
  logic [PW-1:0] ph_cnt;
  logic [FW-1:0] fail_cnt;
  logic          cyc_end;
  logic          cyc_bad;

  assign cyc_end = drv_ok && tx_in && !tx_q;
  assign cyc_bad = cyc_end && !seen;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      tx_q   <= 1'b1;
      seen   <= 1'b0;
      ph_cnt <= '0;
    end else begin
      tx_q <= tx_in;
      if (!drv_ok || tx_in) begin
        seen   <= 1'b0;
        ph_cnt <= '0;
      end else begin
        if (bus_dom && (ph_cnt < PW'(LOOP_DLY))) seen <= 1'b1;
        if (ph_cnt != PW'(LOOP_DLY)) ph_cnt <= ph_cnt + 1'b1;
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                fail_cnt <= '0;
    else if (!drv_ok)          fail_cnt <= '0;
    else if (cyc_end) begin
      if (!cyc_bad)            fail_cnt <= '0;
      else if (fail_cnt != FW'(FAIL_CYCLES)) fail_cnt <= fail_cnt + 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) bus_fail <= 1'b0;
    else if (cyc_bad && (fail_cnt >= FW'(FAIL_CYCLES - 1))) bus_fail <= 1'b1;
    else if (enter_norm) bus_fail <= 1'b0;
  end
endmodule

// File: rtl/txpath_fault_mon.sv
module txpath_fault_mon
  import txfm_pkg::*;
#(
  parameter int TXD_TO_CYC  = 100000,
  parameter int SHORT_CYC   = 16,
  parameter int BUS_TO_CYC  = 100000,
  parameter int LOOP_DLY    = 8,
  parameter int FAIL_CYCLES = 4
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic [1:0] mode,
  input  logic       tx_in,
  input  logic       rx_in,
  input  logic       bus_dom,
  input  logic       overtemp,
  output logic       local_fail,
  output logic       tx_disable,
  output logic       bus_fail
);
  logic [1:0] mode_q;
  logic       act;
  logic       enter_norm;
  logic       spec_clr;
  logic       clr_any;
  logic       short_hit;
  logic       clamp_hit;
  logic       clamp_flag;
  logic       drv_ok;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) mode_q <= MD_STANDBY;
    else        mode_q <= mode;
  end

  assign act        = det_active(mode);
  assign enter_norm = entering_normal(mode, mode_q);
  assign spec_clr   = act && release_ok(rx_in, tx_in, overtemp, short_hit, clamp_hit);
  assign clr_any    = enter_norm || spec_clr;

  txfm_local_faults #(
    .TXD_TO_CYC(TXD_TO_CYC),
    .SHORT_CYC (SHORT_CYC),
    .BUS_TO_CYC(BUS_TO_CYC)
  ) u_local (
    .clk        (clk),
    .rst_n      (rst_n),
    .act        (act),
    .tx_in      (tx_in),
    .rx_in      (rx_in),
    .bus_dom    (bus_dom),
    .overtemp   (overtemp),
    .clr        (clr_any),
    .short_hit  (short_hit),
    .clamp_hit  (clamp_hit),
    .latched_any(tx_disable),
    .clamp_flag (clamp_flag)
  );

  assign local_fail = tx_disable || clamp_flag;
  assign drv_ok     = (mode == MD_NORMAL) && !tx_disable;

  txfm_bus_fault #(
    .LOOP_DLY   (LOOP_DLY),
    .FAIL_CYCLES(FAIL_CYCLES)
  ) u_busf (
    .clk       (clk),
    .rst_n     (rst_n),
    .drv_ok    (drv_ok),
    .tx_in     (tx_in),
    .bus_dom   (bus_dom),
    .enter_norm(enter_norm),
    .bus_fail  (bus_fail)
  );
endmodule

// File: rtl/txfm_checker.sv
module txfm_checker (
  input logic clk,
  input logic rst_n,
  input logic act,
  input logic overtemp,
  input logic bus_dom,
  input logic enter_norm,
  input logic spec_clr,
  input logic clamp_flag,
  input logic local_fail,
  input logic tx_disable,
  input logic bus_fail
);
  AST_DISABLE_IMPLIES_FLAG: assert property (@(posedge clk) disable iff (!rst_n)
    tx_disable |-> local_fail); // R6

  AST_OVERTEMP_LATCH: assert property (@(posedge clk) disable iff (!rst_n)
    (act && overtemp) |=> (local_fail && tx_disable)); // R3

  AST_DISABLE_HOLDS: assert property (@(posedge clk) disable iff (!rst_n)
    (tx_disable && !enter_norm && !spec_clr) |=> tx_disable); // R6

  AST_CLAMP_RELEASE: assert property (@(posedge clk) disable iff (!rst_n)
    !bus_dom |=> !clamp_flag); // R5

  AST_IDLE_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
    (!act && !local_fail) |=> !local_fail); // R9

  AST_BUSFAIL_ENTRY_CLEAR: assert property (@(posedge clk) disable iff (!rst_n)
    enter_norm |=> !bus_fail); // R11
endmodule

bind txpath_fault_mon txfm_checker u_chk (.*);

// File: tb/test_txpath_fault_mon.sv
module test_txpath_fault_mon;
  localparam logic [1:0] M_STBY = 2'b00;
  localparam logic [1:0] M_NORM = 2'b01;
  localparam logic [1:0] M_LSTN = 2'b10;
  localparam logic [1:0] M_SLP  = 2'b11;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic [1:0] mode = M_STBY;
  logic       tx_in = 1'b1, rx_in = 1'b1, bus_dom = 1'b0, overtemp = 1'b0;
  logic       local_fail, tx_disable, bus_fail;

  int checks = 0;
  int errors = 0;
  bit done = 1'b0;

  typedef struct {
    logic  lf;
    logic  dis;
    logic  bf;
    string tag;
  } exp_t;

  exp_t q[$];
  exp_t e;

  always #10 clk = ~clk;

  txpath_fault_mon #(
    .TXD_TO_CYC(8), .SHORT_CYC(3), .BUS_TO_CYC(6), .LOOP_DLY(2), .FAIL_CYCLES(4)
  ) i_txpath_fault_mon (
    .clk(clk), .rst_n(rst_n), .mode(mode), .tx_in(tx_in), .rx_in(rx_in),
    .bus_dom(bus_dom), .overtemp(overtemp),
    .local_fail(local_fail), .tx_disable(tx_disable), .bus_fail(bus_fail)
  );

  task automatic drv(input logic [1:0] m, input logic t, input logic r,
                     input logic b, input logic o);
    mode = m; tx_in = t; rx_in = r; bus_dom = b; overtemp = o;
  endtask

  task automatic tick(input int n);
    repeat (n) @(posedge clk);
    #1;
  endtask

  task automatic expect_out(input logic lf, input logic dis, input logic bf, input string tag);
    exp_t x;
    x.lf = lf; x.dis = dis; x.bf = bf; x.tag = tag;
    q.push_back(x);
  endtask

  // monitor: compares queued expectations on the falling edge
  always @(negedge clk) begin
    while (q.size() > 0) begin
      e = q.pop_front();
      checks++;
      if (local_fail !== e.lf || tx_disable !== e.dis || bus_fail !== e.bf) begin
        errors++;
        $display("FAIL %s: got lf=%0b dis=%0b bf=%0b expected lf=%0b dis=%0b bf=%0b",
                 e.tag, local_fail, tx_disable, bus_fail, e.lf, e.dis, e.bf);
      end
    end
  end

  task automatic fail_cycle();
    drv(M_NORM, 1'b0, 1'b1, 1'b0, 1'b0); tick(3);
    drv(M_NORM, 1'b1, 1'b1, 1'b0, 1'b0); tick(1);
  endtask

  initial begin
    tick(3);
    expect_out(0, 0, 0, "R1 in reset");
    rst_n = 1'b1;
    tick(1);
    expect_out(0, 0, 0, "R1 after release");

    // R9: inactive modes ignore every fault source
    drv(M_SLP, 1'b0, 1'b0, 1'b0, 1'b1); tick(12);
    expect_out(0, 0, 0, "R9 sleep ignores txd and overtemp");
    drv(M_STBY, 1'b1, 1'b0, 1'b1, 1'b0); tick(10);
    expect_out(0, 0, 0, "R9 standby ignores clamp");

    // R2: transmit dominant timeout boundary
    drv(M_NORM, 1'b0, 1'b1, 1'b0, 1'b0); tick(8);
    expect_out(0, 0, 0, "R2 no fault at limit");
    tick(1);
    expect_out(1, 1, 0, "R2 timeout sets");
    drv(M_NORM, 1'b1, 1'b1, 1'b0, 1'b0); tick(3);
    expect_out(1, 1, 0, "R6 timeout latched");

    // R8: receive dominant with transmit recessive releases
    drv(M_NORM, 1'b1, 1'b0, 1'b0, 1'b0); tick(1);
    expect_out(0, 0, 0, "R8 release clear");
    drv(M_NORM, 1'b1, 1'b1, 1'b0, 1'b0); tick(1);

    // R4: transmit-to-receive short
    drv(M_NORM, 1'b1, 1'b0, 1'b0, 1'b0); tick(3);
    expect_out(0, 0, 0, "R4 no short at limit");
    tick(1);
    expect_out(1, 1, 0, "R4 short sets");
    drv(M_NORM, 1'b1, 1'b1, 1'b0, 1'b0); tick(2);
    expect_out(1, 1, 0, "R6 short latched");
    drv(M_LSTN, 1'b1, 1'b1, 1'b0, 1'b0); tick(1);
    drv(M_NORM, 1'b1, 1'b1, 1'b0, 1'b0); tick(1);
    expect_out(0, 0, 0, "R7 entry clears");

    // R5: clamped bus, not latched, no disable
    drv(M_NORM, 1'b1, 1'b0, 1'b1, 1'b0); tick(6);
    expect_out(0, 0, 0, "R5 no clamp at limit");
    tick(1);
    expect_out(1, 0, 0, "R5 clamp flags only");
    drv(M_NORM, 1'b1, 1'b1, 1'b0, 1'b0); tick(1);
    expect_out(0, 0, 0, "R5 clamp releases");

    // R3: overtemperature, and R8 blocked while hot
    drv(M_NORM, 1'b1, 1'b1, 1'b0, 1'b1); tick(1);
    expect_out(1, 1, 0, "R3 overtemp sets");
    drv(M_NORM, 1'b1, 1'b1, 1'b0, 1'b0); tick(2);
    expect_out(1, 1, 0, "R6 overtemp latched");
    drv(M_NORM, 1'b1, 1'b0, 1'b0, 1'b1); tick(1);
    expect_out(1, 1, 0, "R8 blocked by overtemp");
    drv(M_NORM, 1'b1, 1'b0, 1'b0, 1'b0); tick(1);
    expect_out(0, 0, 0, "R8 clear after cool");
    drv(M_NORM, 1'b1, 1'b1, 1'b0, 1'b0); tick(1);

    // R12: fresh overtemp on the entry-into-normal edge
    drv(M_LSTN, 1'b1, 1'b1, 1'b0, 1'b0); tick(1);
    drv(M_NORM, 1'b1, 1'b1, 1'b0, 1'b1); tick(1);
    expect_out(1, 1, 0, "R12 set beats entry clear");
    drv(M_LSTN, 1'b1, 1'b1, 1'b0, 1'b0); tick(1);
    drv(M_NORM, 1'b1, 1'b1, 1'b0, 1'b0); tick(1);
    expect_out(0, 0, 0, "R7 entry clears again");

    // R10: bus fault counting
    fail_cycle(); fail_cycle(); fail_cycle();
    expect_out(0, 0, 0, "R10 three fails");
    drv(M_NORM, 1'b0, 1'b0, 1'b1, 1'b0); tick(1);
    drv(M_NORM, 1'b0, 1'b1, 1'b0, 1'b0); tick(2);
    drv(M_NORM, 1'b1, 1'b1, 1'b0, 1'b0); tick(1);
    expect_out(0, 0, 0, "R10 good cycle");
    drv(M_NORM, 1'b0, 1'b1, 1'b0, 1'b0); tick(2);
    drv(M_NORM, 1'b0, 1'b0, 1'b1, 1'b0); tick(1);
    drv(M_NORM, 1'b1, 1'b1, 1'b0, 1'b0); tick(1);
    fail_cycle(); fail_cycle();
    expect_out(0, 0, 0, "R10 count restarted");
    fail_cycle();
    expect_out(0, 0, 1, "R10 fourth fail sets");
    tick(3);
    expect_out(0, 0, 1, "R10 bus fail held");

    // R11: entry into normal clears bus fail
    drv(M_LSTN, 1'b1, 1'b1, 1'b0, 1'b0); tick(1);
    drv(M_NORM, 1'b1, 1'b1, 1'b0, 1'b0); tick(1);
    expect_out(0, 0, 0, "R11 entry clears bus fail");

    @(negedge clk); #1;
    if (!done) begin
      done = 1'b1;
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      done = 1'b1;
      checks++;
      errors++;
      $display("FAIL watchdog: got running expected finished");
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end
endmodule